// File: doc/BRIEF.md
# Data Eye Centre and Width Calculator

This block finishes a strobe-position training pass for one chip-select pair. Edge finding has already produced, for every byte lane, a left edge and a right edge in abstract steps of 1/32 UI. On a start pulse the block walks the lanes in ascending order, one lane per clock cycle. For each enabled lane it converts both edges, the eye width and the eye centre into register units through a min/max/mask scaling model. It then compares the width against a minimum, presents the centre as a write to that lane's delay register, and forms the value to keep in the trained-delay table.

Training runs in one of two directions. A read pass stores the centre as it is. A write pass stores the centre plus the lane's write-strobe delay. A narrow eye raises a sticky error and ends the pass at that lane. The saved-lane mask records which lanes were stored cleanly, and it takes a fixed pattern in its upper bits once an error has occurred.

Top module: `eye_center_calc`

## Requirements
- R1: A value d in 1/32 UI scales to `(scaleMin + d * f) & scaleMask`, truncated to 8 bits. Here f = (scaleMax - scaleMin) / 32, using signed integer division that truncates toward zero, so scaleMax below scaleMin gives a negative f. leftScaled and rightScaled are the scaled left and right edges of the lane being reported.
- R2: eyeWidth is the scaled value of (right - left), where both edges are sign-extended 8-bit values.
- R3: eyeCentre is the scaled value of (left + right + 1) / 2. Both edges are sign-extended before the sum, and the division truncates toward zero.
- R4: smallWindow is 1 for a lane whose eyeWidth is below the scaled minWidth, comparing both as unsigned 8-bit numbers. errFlag goes to 1 with that lane's result and stays at 1 until the next accepted start clears it.
- R5: A start seen high at edge E0 while idle begins a pass. Lane i is evaluated at edge E(i+1). If bit i of laneEn is 1, dlyWrEn is high for the one cycle after that edge, with dlyLane = i and eyeCentre as the register value. A disabled lane produces no strobe.
- R6: An accepted start clears savedMask. A lane stored without error sets bit i of savedMask. A lane that sets the error instead sets all bits from MASK_W-1 down to NUM_LANES (0xFE00 by default) and leaves its own bit clear.
- R7: With dirWrite = 0, storeValue equals eyeCentre. With dirWrite = 1, storeValue is (eyeCentre + wrStrobeDly[i]) mod 256.
- R8: storeIdx = (chipSel / 2) * TABLE_W + i, where i is the lane reported.
- R9: After a lane raises the error, no later lane is evaluated, even if it is enabled.
- R10: The last lane evaluated is lane NUM_LANES-1, or the lane that raised the error. With that lane's edge called E(k+1), busy is high after E0 up to and including the cycle after E(k+1). done is high for exactly the one cycle after E(k+2), with busy low.
- R11: A start while busy has no effect. The lane sequence, savedMask and errFlag continue as if it had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| dirWrite | input | 1 | 1 = write-data pass, 0 = read-strobe pass |
| chipSel | input | CS_W | Chip select being trained |
| laneEn | input | NUM_LANES | Per-lane enable |
| leftEdge | input | NUM_LANES x 8 | Signed left edge per lane, 1/32 UI |
| rightEdge | input | NUM_LANES x 8 | Signed right edge per lane, 1/32 UI |
| wrStrobeDly | input | NUM_LANES x 8 | Per-lane write-strobe delay added in write passes |
| minWidth | input | 8 | Signed minimum eye width, 1/32 UI |
| scaleMin | input | 8 | Register value for delay 0 |
| scaleMax | input | 8 | Register value spanning 32 steps above scaleMin |
| scaleMask | input | 8 | Mask applied to every scaled value |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| dlyWrEn | output | 1 | Delay register write strobe |
| dlyLane | output | LANE_W | Lane of the reported result |
| leftScaled | output | 8 | Scaled left edge |
| rightScaled | output | 8 | Scaled right edge |
| eyeWidth | output | 8 | Scaled eye width |
| eyeCentre | output | 8 | Scaled eye centre, value for the delay register |
| smallWindow | output | 1 | Reported lane's eye is narrower than the minimum |
| errFlag | output | 1 | Sticky error for the current pass |
| savedMask | output | MASK_W | Lanes stored cleanly, plus the error pattern |
| storeValue | output | 8 | Value for the trained-delay table |
| storeIdx | output | IDX_W | Index into the trained-delay table |

## Verification
The hardest situation to reach is an abort in the middle of a pass. A lane in the middle must have a narrow eye while earlier lanes are clean and later lanes are still enabled, and the sequence and timing of done must then shift to that lane. The stimulus sweeps edge patterns, minimum widths, enable masks and four scaling sets, including a negative scale factor, so the first narrow lane falls at many positions. Some passes also carry a second start pulse in their middle, to show that it leaves the lane stream and the mask untouched.

// File: rtl/eye_pkg.sv
`timescale 1ns/1ps
package eye_pkg;
  localparam int DLY_W    = 8;
  localparam int CALC_W   = 10;
  localparam int UI_STEPS = 32;

  typedef struct packed {
    logic clear;
    logic process;
  } eye_strobe_t;

  // abstract 1/32 UI value -> register units through the min/max/mask model
  function automatic logic [DLY_W-1:0] scaleDly(
    input logic signed [CALC_W-1:0] d,
    input logic [DLY_W-1:0] mn,
    input logic [DLY_W-1:0] mx,
    input logic [DLY_W-1:0] msk
  );
    logic signed [CALC_W-1:0]   span;
    logic signed [CALC_W-1:0]   factor;
    logic signed [2*CALC_W-1:0] prod;
    logic signed [2*CALC_W-1:0] total;
    span   = $signed({{(CALC_W-DLY_W){1'b0}}, mx}) - $signed({{(CALC_W-DLY_W){1'b0}}, mn});
    factor = span / $signed(CALC_W'(UI_STEPS));
    prod   = d * factor;
    total  = $signed({{(2*CALC_W-DLY_W){1'b0}}, mn}) + prod;
    return total[DLY_W-1:0] & msk;
  endfunction
endpackage

// File: rtl/eye_ctrl.sv
`timescale 1ns/1ps
module eye_ctrl import eye_pkg::*; #(
  parameter int NUM_LANES = 9,
  parameter int LANE_W    = $clog2(NUM_LANES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [NUM_LANES-1:0] laneEn,
  input  logic                 laneShort,
  output eye_strobe_t          strb,
  output logic [LANE_W-1:0]    lane,
  output logic                 busy,
  output logic                 done
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrl_state_t;
  ctrl_state_t state;

  always_comb begin
    strb         = '0;
    strb.clear   = (state == ST_IDLE) && start;
    strb.process = (state == ST_RUN) && laneEn[lane];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lane  <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          lane  <= '0;
        end
        ST_RUN: begin
          if (lane == LAST_LANE || (strb.process && laneShort)) state <= ST_FIN;
          else lane <= lane + LANE_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/eye_datapath.sv
`timescale 1ns/1ps
module eye_datapath import eye_pkg::*; #(
  parameter int NUM_LANES = 9,
  parameter int CS_W      = 3,
  parameter int TABLE_W   = 9,
  parameter int MASK_W    = 16,
  parameter int LANE_W    = $clog2(NUM_LANES),
  parameter int IDX_W     = $clog2((2**CS_W/2)*TABLE_W)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  eye_strobe_t                      strb,
  input  logic [LANE_W-1:0]                lane,
  input  logic                             dirWrite,
  input  logic [CS_W-1:0]                  chipSel,
  input  logic [NUM_LANES-1:0][DLY_W-1:0]  leftEdge,
  input  logic [NUM_LANES-1:0][DLY_W-1:0]  rightEdge,
  input  logic [NUM_LANES-1:0][DLY_W-1:0]  wrStrobeDly,
  input  logic [DLY_W-1:0]                 minWidth,
  input  logic [DLY_W-1:0]                 scaleMin,
  input  logic [DLY_W-1:0]                 scaleMax,
  input  logic [DLY_W-1:0]                 scaleMask,
  output logic                             laneShort,
  output logic                             dlyWrEn,
  output logic [LANE_W-1:0]                dlyLane,
  output logic [DLY_W-1:0]                 leftScaled,
  output logic [DLY_W-1:0]                 rightScaled,
  output logic [DLY_W-1:0]                 eyeWidth,
  output logic [DLY_W-1:0]                 eyeCentre,
  output logic                             smallWindow,
  output logic                             errFlag,
  output logic [MASK_W-1:0]                savedMask,
  output logic [DLY_W-1:0]                 storeValue,
  output logic [IDX_W-1:0]                 storeIdx
);
  localparam logic [MASK_W-1:0] ERR_PATTERN = {{(MASK_W-NUM_LANES){1'b1}}, {NUM_LANES{1'b0}}};

  logic signed [DLY_W-1:0]  leftSel, rightSel;
  logic signed [CALC_W-1:0] leftExt, rightExt, edgeDiff, edgeSum, midPoint, minExt;
  logic [DLY_W-1:0]         leftS, rightS, widthS, centreS, minS, strobeAdd;
  logic [IDX_W-1:0]         idxNext;

  always_comb begin
    leftSel   = $signed(leftEdge[lane]);
    rightSel  = $signed(rightEdge[lane]);
    leftExt   = CALC_W'(leftSel);
    rightExt  = CALC_W'(rightSel);
    minExt    = CALC_W'($signed(minWidth));
    edgeDiff  = rightExt - leftExt;
    edgeSum   = leftExt + rightExt + $signed(CALC_W'(1));
    midPoint  = edgeSum / $signed(CALC_W'(2));
    leftS     = scaleDly(leftExt,  scaleMin, scaleMax, scaleMask);
    rightS    = scaleDly(rightExt, scaleMin, scaleMax, scaleMask);
    widthS    = scaleDly(edgeDiff, scaleMin, scaleMax, scaleMask);
    centreS   = scaleDly(midPoint, scaleMin, scaleMax, scaleMask);
    minS      = scaleDly(minExt,   scaleMin, scaleMax, scaleMask);
    laneShort = widthS < minS;
    strobeAdd = dirWrite ? wrStrobeDly[lane] : '0;
    idxNext   = IDX_W'(chipSel >> 1) * IDX_W'(TABLE_W) + IDX_W'(lane);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyWrEn     <= 1'b0;
      dlyLane     <= '0;
      leftScaled  <= '0;
      rightScaled <= '0;
      eyeWidth    <= '0;
      eyeCentre   <= '0;
      smallWindow <= 1'b0;
      errFlag     <= 1'b0;
      savedMask   <= '0;
      storeValue  <= '0;
      storeIdx    <= '0;
    end else begin
      dlyWrEn <= strb.process;
      if (strb.clear) begin
        errFlag   <= 1'b0;
        savedMask <= '0;
      end
      if (strb.process) begin
        dlyLane     <= lane;
        leftScaled  <= leftS;
        rightScaled <= rightS;
        eyeWidth    <= widthS;
        eyeCentre   <= centreS;
        smallWindow <= laneShort;
        storeValue  <= centreS + strobeAdd;
        storeIdx    <= idxNext;
        if (laneShort || errFlag) begin
          errFlag   <= 1'b1;
          savedMask <= savedMask | ERR_PATTERN;
        end else begin
          savedMask <= savedMask | (MASK_W'(1) << lane);
        end
      end
    end
  end
endmodule

// File: rtl/eye_center_calc.sv
`timescale 1ns/1ps
module eye_center_calc import eye_pkg::*; #(
  parameter int NUM_LANES = 9,
  parameter int CS_W      = 3,
  parameter int TABLE_W   = 9,
  parameter int MASK_W    = 16,
  localparam int LANE_W   = $clog2(NUM_LANES),
  localparam int IDX_W    = $clog2((2**CS_W/2)*TABLE_W)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic                             dirWrite,
  input  logic [CS_W-1:0]                  chipSel,
  input  logic [NUM_LANES-1:0]             laneEn,
  input  logic [NUM_LANES-1:0][DLY_W-1:0]  leftEdge,
  input  logic [NUM_LANES-1:0][DLY_W-1:0]  rightEdge,
  input  logic [NUM_LANES-1:0][DLY_W-1:0]  wrStrobeDly,
  input  logic [DLY_W-1:0]                 minWidth,
  input  logic [DLY_W-1:0]                 scaleMin,
  input  logic [DLY_W-1:0]                 scaleMax,
  input  logic [DLY_W-1:0]                 scaleMask,
  output logic                             busy,
  output logic                             done,
  output logic                             dlyWrEn,
  output logic [LANE_W-1:0]                dlyLane,
  output logic [DLY_W-1:0]                 leftScaled,
  output logic [DLY_W-1:0]                 rightScaled,
  output logic [DLY_W-1:0]                 eyeWidth,
  output logic [DLY_W-1:0]                 eyeCentre,
  output logic                             smallWindow,
  output logic                             errFlag,
  output logic [MASK_W-1:0]                savedMask,
  output logic [DLY_W-1:0]                 storeValue,
  output logic [IDX_W-1:0]                 storeIdx
);
  eye_strobe_t       strb;
  logic [LANE_W-1:0] lane;
  logic              laneShort;

  eye_ctrl #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .laneEn(laneEn), .laneShort(laneShort),
    .strb(strb), .lane(lane), .busy(busy), .done(done)
  );

  eye_datapath #(
    .NUM_LANES(NUM_LANES), .CS_W(CS_W), .TABLE_W(TABLE_W), .MASK_W(MASK_W),
    .LANE_W(LANE_W), .IDX_W(IDX_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .lane(lane), .dirWrite(dirWrite),
    .chipSel(chipSel), .leftEdge(leftEdge), .rightEdge(rightEdge),
    .wrStrobeDly(wrStrobeDly), .minWidth(minWidth), .scaleMin(scaleMin),
    .scaleMax(scaleMax), .scaleMask(scaleMask), .laneShort(laneShort),
    .dlyWrEn(dlyWrEn), .dlyLane(dlyLane), .leftScaled(leftScaled),
    .rightScaled(rightScaled), .eyeWidth(eyeWidth), .eyeCentre(eyeCentre),
    .smallWindow(smallWindow), .errFlag(errFlag), .savedMask(savedMask),
    .storeValue(storeValue), .storeIdx(storeIdx)
  );
endmodule

// File: rtl/eye_center_checker.sv
`timescale 1ns/1ps
module eye_center_checker #(
  parameter int NUM_LANES = 9,
  parameter int MASK_W    = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              dlyWrEn,
  input logic              smallWindow,
  input logic              errFlag,
  input logic [MASK_W-1:0] savedMask
);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_strobe_in_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    dlyWrEn |-> busy);

  assert_small_sets_error_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dlyWrEn && smallWindow) |-> errFlag);

  assert_error_pattern_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (&savedMask[MASK_W-1:NUM_LANES]));

  assert_halt_after_error_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> !dlyWrEn);

  assert_error_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> errFlag);
endmodule

bind eye_center_calc eye_center_checker #(.NUM_LANES(NUM_LANES), .MASK_W(MASK_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .dlyWrEn(dlyWrEn), .smallWindow(smallWindow), .errFlag(errFlag),
  .savedMask(savedMask)
);

// File: tb/sim_eye_center_calc.sv
`timescale 1ns/1ps
module sim_eye_center_calc;
  localparam int NL  = 9;
  localparam int CSW = 3;
  localparam int TW  = 9;
  localparam int MW  = 16;
  localparam int LW  = $clog2(NL);
  localparam int IW  = $clog2((2**CSW/2)*TW);
  localparam int ERR_PAT = 32'hFE00;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rstN, start, dirWrite;
  logic [CSW-1:0]       chipSel;
  logic [NL-1:0]        laneEn;
  logic [NL-1:0][7:0]   leftEdge, rightEdge, wrStrobeDly;
  logic [7:0]           minWidth, scaleMin, scaleMax, scaleMask;
  logic                 busy, done, dlyWrEn, smallWindow, errFlag;
  logic [LW-1:0]        dlyLane;
  logic [7:0]           leftScaled, rightScaled, eyeWidth, eyeCentre, storeValue;
  logic [MW-1:0]        savedMask;
  logic [IW-1:0]        storeIdx;

  eye_center_calc #(.NUM_LANES(NL), .CS_W(CSW), .TABLE_W(TW), .MASK_W(MW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .dirWrite(dirWrite), .chipSel(chipSel),
    .laneEn(laneEn), .leftEdge(leftEdge), .rightEdge(rightEdge),
    .wrStrobeDly(wrStrobeDly), .minWidth(minWidth), .scaleMin(scaleMin),
    .scaleMax(scaleMax), .scaleMask(scaleMask), .busy(busy), .done(done),
    .dlyWrEn(dlyWrEn), .dlyLane(dlyLane), .leftScaled(leftScaled),
    .rightScaled(rightScaled), .eyeWidth(eyeWidth), .eyeCentre(eyeCentre),
    .smallWindow(smallWindow), .errFlag(errFlag), .savedMask(savedMask),
    .storeValue(storeValue), .storeIdx(storeIdx)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bscale(input int d, input int mn, input int mx, input int mk);
    int f;
    f = (mx - mn) / 32;
    return (mn + d * f) & mk & 255;
  endfunction

  task automatic runCase(input bit midStart);
    int eL[NL], eR[NL], eW[NL], eC[NL], eS[NL], eV[NL], eI[NL];
    int lastLane, mn, mx, mk, minS, runMask, runErr;
    lastLane = NL - 1;
    mn = scaleMin; mx = scaleMax; mk = scaleMask;
    minS = bscale(int'($signed(minWidth)), mn, mx, mk);
    for (int l = 0; l < NL; l++) begin
      int lv, rv;
      lv = int'($signed(leftEdge[l]));
      rv = int'($signed(rightEdge[l]));
      eL[l] = bscale(lv, mn, mx, mk);
      eR[l] = bscale(rv, mn, mx, mk);
      eW[l] = bscale(rv - lv, mn, mx, mk);
      eC[l] = bscale((lv + rv + 1) / 2, mn, mx, mk);
      eS[l] = (eW[l] < minS) ? 1 : 0;
      eV[l] = (eC[l] + (dirWrite ? int'(wrStrobeDly[l]) : 0)) & 255;
      eI[l] = (int'(chipSel) / 2) * TW + l;
    end
    for (int l = NL - 1; l >= 0; l--)
      if (laneEn[l] && eS[l] == 1) lastLane = l;
    if (lastLane < 3) midStart = 1'b0;
    runMask = 0;
    runErr  = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    for (int c = 1; c <= lastLane + 3; c++) begin
      int l;
      bit ew;
      @(posedge clk);
      @(negedge clk);
      l  = c - 1;
      ew = (c <= lastLane + 1) && laneEn[l];
      chk((c > lastLane + 1) ? "R9" : "R5", "dlyWrEn", int'(dlyWrEn), int'(ew));
      if (ew) begin
        if (eS[l] == 1) begin runErr = 1; runMask |= ERR_PAT; end
        else runMask |= (1 << l);
        if (dlyWrEn) begin
          chk("R5", "dlyLane", int'(dlyLane), l);
          chk("R1", "leftScaled", int'(leftScaled), eL[l]);
          chk("R1", "rightScaled", int'(rightScaled), eR[l]);
          chk("R2", "eyeWidth", int'(eyeWidth), eW[l]);
          chk("R3", "eyeCentre", int'(eyeCentre), eC[l]);
          chk("R4", "smallWindow", int'(smallWindow), eS[l]);
          chk("R7", "storeValue", int'(storeValue), eV[l]);
          chk("R8", "storeIdx", int'(storeIdx), eI[l]);
        end
      end
      chk("R6", "savedMask", int'(savedMask), runMask);
      chk("R4", "errFlag", int'(errFlag), runErr);
      chk("R10", "done", int'(done), int'(c == lastLane + 2));
      chk("R10", "busy", int'(busy), int'(c <= lastLane + 1));
      start = (midStart && c == 2) ? 1'b1 : 1'b0;  // R11: extra start while busy
    end
    @(posedge clk);
    @(negedge clk);
    chk("R10", "done after pulse", int'(done), 0);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; dirWrite = 1'b0; chipSel = '0; laneEn = '1;
    leftEdge = '0; rightEdge = '0; wrStrobeDly = '0;
    minWidth = '0; scaleMin = '0; scaleMax = '0; scaleMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R5", "reset dlyWrEn", int'(dlyWrEn), 0);
    chk("R10", "reset busy", int'(busy), 0);
    chk("R10", "reset done", int'(done), 0);
    chk("R6", "reset savedMask", int'(savedMask), 0);
    chk("R4", "reset errFlag", int'(errFlag), 0);

    for (int sc = 0; sc < 4; sc++)
      for (int dr = 0; dr < 2; dr++)
        for (int p = 0; p < 6; p++)
          for (int en = 0; en < 3; en++)
            for (int mw = 0; mw < 3; mw++) begin
              @(negedge clk);
              case (sc)
                0: begin scaleMin = 8'd0;   scaleMax = 8'd255; scaleMask = 8'hFF; end
                1: begin scaleMin = 8'd16;  scaleMax = 8'd80;  scaleMask = 8'h7F; end
                2: begin scaleMin = 8'd5;   scaleMax = 8'd40;  scaleMask = 8'hFF; end
                default: begin scaleMin = 8'd100; scaleMax = 8'd20; scaleMask = 8'hFF; end
              endcase
              dirWrite = dr[0];
              chipSel  = CSW'(p);
              case (en)
                0: laneEn = '1;
                1: laneEn = 9'h155;
                default: laneEn = (p == 5) ? 9'h000 : 9'h0D6;
              endcase
              case (mw)
                0: minWidth = 8'd0;
                1: minWidth = 8'd3;
                default: minWidth = 8'd8;
              endcase
              for (int l = 0; l < NL; l++) begin
                int lv, rv;
                lv = ((p * 7 + l * 5) % 24) - 12;
                rv = lv + ((p * 3 + l * 11 + mw) % 20) - 2;
                leftEdge[l]    = 8'(lv);
                rightEdge[l]   = 8'(rv);
                wrStrobeDly[l] = 8'((l * 37 + p * 13) & 255);
              end
              runCase(p == 1);
            end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule